// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block receives asynchronous serial frames on a single input line and makes them available to software through a small register interface. The line is sampled on a strobe that runs at sixteen times the bit rate. A start bit must still be low at its midpoint to be accepted. The receiver then shifts in 7 or 8 data bits, least significant first. An optional even or odd parity bit follows, and then the stop bit. Each received byte goes to a data register.

A status register holds four flags: a byte-ready flag and three error flags (overrun, parity, framing). Each flag is cleared by software in two steps. Software first reads the flag as 1, then writes 0 to it. While any error flag is set, the receiver refuses to start new frames. The status register also shows the raw line level, so software can tell a break from a single bad frame. An interrupt line pulses for one cycle whenever the byte-ready flag goes from 0 to 1.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, the control register reads 0 (receiver off), the status flags read 0, and `irq` is 0.
- R2: With the receiver on, a valid frame stores its data bits, received least significant first, in the data register (select 2). In the same clock edge, the byte-ready flag (status bit 0) sets.
- R3: Control bit 1 turns parity on, and control bit 2 picks odd parity (1) or even parity (0). Control bit 3 selects 7 data bits, which read back with bit 7 equal to 0. A parity mismatch sets status bit 2. The byte is still stored and byte-ready still sets.
- R4: A start bit is confirmed by the eighth sample after the falling edge is seen. A low pulse that has returned high by that sample is discarded and changes nothing.
- R5: A stop bit sampled low sets the framing flag (status bit 3). The byte is still written to the data register, but byte-ready does not set.
- R6: The overrun decision is made at the stop-bit sample. If byte-ready is still 1 at that point, the overrun flag (status bit 1) sets and the data register keeps the earlier byte. If byte-ready was cleared before that point, no overrun occurs.
- R7: While any of the three error flags is 1, no new frame is accepted. Reception resumes only after all three have been cleared.
- R8: A flag clears only when a status write carries 0 in its bit position and that flag was read as 1 (a `reg_rd` of select 1) since it last set. A write of 1 never changes a flag, and a write of 0 without a prior read does not clear it.
- R9: `irq` is high for exactly one cycle, in the cycle where byte-ready has just gone from 0 to 1.
- R10: Control bit 0 enables the receiver. A frame that arrives while it is 0 is ignored. Clearing it in the middle of a frame abandons that frame.
- R11: Status bit 4 always shows the current level of `rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Sample strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high, already synchronous to clk |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_rd | input | 1 | Read strobe; reading the status register records which flags were seen as 1 |
| reg_wr | input | 1 | Write strobe to the selected register |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | One-cycle pulse when byte-ready sets |

## Verification
Take tick as running every cycle, and count from the edge at which the low start level is first seen. The start check falls 8 edges later, and data bit k is sampled 24 + 16k edges later. The stop sample comes 16·(n+1) + 8 edges later, where n counts the data and parity bits. The flags, the data register and `irq` all change at that stop edge. A register write takes effect at the edge that samples the write strobe. The line-level bit follows `rxd` with no delay. The bench holds each serial bit for 16 cycles and updates its behavioural model at exactly those edges. It compares the status flags, the line bit and `irq` with the model at every falling edge, and reads the data register between frames.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] reg_sel,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [3:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t          state;
  logic [CW-1:0] cnt;
  logic [2:0]   bitn;
  logic [7:0]   shreg, rdr;
  logic [3:0]   ctrl, armed;
  logic         pacc, par_bad;
  logic         full, ovr, perr, ferr;

  wire rx_en   = ctrl[0];
  wire any_err = ovr | perr | ferr;
  wire [2:0] last_bit = ctrl[3] ? 3'd6 : 3'd7;
  wire [7:0] data_val = ctrl[3] ? {1'b0, shreg[7:1]} : shreg;
  wire at_end  = tick && (cnt == LAST);

  wire stop_ev  = rx_en && state == S_STOP && at_end;
  wire set_full = stop_ev && !full && rxd;
  wire set_ovr  = stop_ev && full;
  wire set_perr = stop_ev && !full && par_bad;
  wire set_ferr = stop_ev && !full && !rxd;

  wire [3:0] flags = {ferr, perr, ovr, full};
  wire rd_stat = reg_rd && reg_sel == 2'd1;
  wire wr_stat = reg_wr && reg_sel == 2'd1;
  wire [3:0] clr = wr_stat ? (~reg_wdata & armed) : 4'b0;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {4'b0, ctrl};
      2'd1:    reg_rdata = {3'b0, rxd, flags};
      2'd2:    reg_rdata = rdr;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      pacc <= 1'b0; par_bad <= 1'b0;
    end else if (!rx_en) begin
      state <= S_IDLE;
    end else if (tick) begin
      case (state)
        S_IDLE:
          if (!rxd && !any_err) begin
            state <= S_START; cnt <= '0;
          end
        S_START:
          if (cnt == MID) begin
            cnt <= '0; bitn <= '0; pacc <= 1'b0; par_bad <= 1'b0;
            state <= rxd ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {rxd, shreg[7:1]};
            pacc  <= pacc ^ rxd;
            bitn  <= bitn + 1'b1;
            if (bitn == last_bit) state <= ctrl[1] ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (cnt == LAST) begin
            cnt     <= '0;
            par_bad <= (pacc ^ rxd) != ctrl[2];
            state   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (cnt == LAST) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; armed <= '0; rdr <= '0; irq <= 1'b0;
      full <= 1'b0; ovr <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == 2'd0) ctrl <= reg_wdata;
      full  <= set_full | (full & ~clr[0]);
      ovr   <= set_ovr  | (ovr  & ~clr[1]);
      perr  <= set_perr | (perr & ~clr[2]);
      ferr  <= set_ferr | (ferr & ~clr[3]);
      armed <= (armed | (rd_stat ? flags : 4'b0)) & ~clr;
      if (stop_ev && !full) rdr <= data_val;
      irq <= set_full;
    end
  end

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full && !$past(full)));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && any_err) |=> state == S_IDLE);
  p_ferr_nofull_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr) |-> !$rose(full));
  p_ovr_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rdr));
  p_clear_by_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(wr_stat && !reg_wdata[0]));
  p_off_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(full));
endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
  logic clk = 0, rst_n = 0, tick = 1, rxd = 1;
  logic [1:0] reg_sel = 2'd1;
  logic reg_rd = 0, reg_wr = 0;
  logic [3:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq;

  uart_rx_status uut (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit mon = 0;
  bit m_full, m_ovr, m_perr, m_ferr, m_irq;
  bit [3:0] m_arm, m_ctrl;
  bit [7:0] m_rdr;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon) begin
    if (reg_sel == 2'd1) begin
      chk("R8 flags", reg_rdata[3:0], {m_ferr, m_perr, m_ovr, m_full});
      chk("R11 line", reg_rdata[4], rxd);
    end
    chk("R9 irq", irq, m_irq);
    m_irq = 0;
  end

  task automatic wreg(input bit [1:0] sel, input bit [3:0] v);
    reg_sel = sel; reg_wr = 1; reg_wdata = v;
    @(posedge clk);
    if (sel == 2'd0) m_ctrl = v;
    if (sel == 2'd1) begin
      bit [3:0] c;
      c = ~v & m_arm;
      if (c[0]) m_full = 0;
      if (c[1]) m_ovr = 0;
      if (c[2]) m_perr = 0;
      if (c[3]) m_ferr = 0;
      m_arm &= ~c;
    end
    #1 reg_wr = 0; reg_sel = 2'd1;
    @(negedge clk);
  endtask

  task automatic rstat();
    reg_sel = 2'd1; reg_rd = 1;
    @(posedge clk);
    m_arm |= {m_ferr, m_perr, m_ovr, m_full};
    #1 reg_rd = 0;
    @(negedge clk);
  endtask

  task automatic clr_all();
    rstat();
    wreg(2'd1, 4'h0);
  endtask

  task automatic chk_data(input string req, input bit [7:0] exp);
    #2 reg_sel = 2'd2;
    #1 chk(req, reg_rdata, exp);
    chk({req, " model"}, reg_rdata, m_rdr);
    reg_sel = 2'd1;
    @(negedge clk);
  endtask

  task automatic send(input bit [7:0] d, input bit bad_par, input bit bad_stop, input int abort_bit);
    bit b[12];
    int n, nd;
    bit accept;
    bit [7:0] dv;
    nd = m_ctrl[3] ? 7 : 8;
    dv = m_ctrl[3] ? {1'b0, d[6:0]} : d;
    n = 0;
    b[n++] = 0;
    for (int i = 0; i < nd; i++) b[n++] = d[i];
    if (m_ctrl[1]) b[n++] = (^dv) ^ m_ctrl[2] ^ bad_par;
    b[n++] = !bad_stop;
    accept = m_ctrl[0] && !(m_ovr || m_perr || m_ferr);
    for (int j = 0; j < n; j++) begin
      rxd = b[j];
      if (j == abort_bit) begin
        reg_sel = 2'd0; reg_wr = 1; reg_wdata = m_ctrl & 4'b1110;
      end
      @(posedge clk);
      if (j == abort_bit) begin
        m_ctrl = m_ctrl & 4'b1110; accept = 0;
        #1 reg_wr = 0; reg_sel = 2'd1;
      end
      repeat (8) @(posedge clk);
      if (j == n - 1 && accept) begin
        if (m_full) m_ovr = 1;
        else begin
          m_rdr = dv;
          if (!bad_stop) begin m_full = 1; m_irq = 1; end
          else m_ferr = 1;
          if (m_ctrl[1] && bad_par) m_perr = 1;
        end
      end
      repeat (7) @(posedge clk);
      @(negedge clk);
    end
    rxd = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", reg_rdata, 8'h10);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", reg_rdata[3:0], 0);
    reg_sel = 2'd0; #1 chk("R1 ctrl", reg_rdata, 0); reg_sel = 2'd1;
    mon = 1;
    @(negedge clk);

    send(8'h3C, 0, 0, -1);
    chk("R10 off", m_full, 0);
    chk_data("R10 data kept", 8'h00);

    wreg(2'd0, 4'b0001);
    send(8'hA5, 0, 0, -1);
    chk_data("R2 data", 8'hA5);
    wreg(2'd1, 4'h0);
    chk("R8 no read", reg_rdata[0], 1);
    rstat();
    wreg(2'd1, 4'hF);
    chk("R8 write one", reg_rdata[0], 1);
    wreg(2'd1, 4'h0);
    chk("R8 cleared", reg_rdata[0], 0);

    send(8'h11, 0, 0, -1);
    send(8'h22, 0, 0, -1);
    chk("R6 overrun", reg_rdata[1], 1);
    chk_data("R6 kept", 8'h11);
    send(8'h33, 0, 0, -1);
    chk_data("R7 frozen", 8'h11);
    clr_all();
    chk("R7 all clear", reg_rdata[3:0], 0);
    send(8'h44, 0, 0, -1);
    chk_data("R7 resumed", 8'h44);
    clr_all();
    send(8'h01, 0, 0, -1);
    clr_all();
    send(8'h02, 0, 0, -1);
    chk("R6 no overrun", reg_rdata[1], 0);
    chk_data("R6 new byte", 8'h02);
    clr_all();

    wreg(2'd0, 4'b0011);
    send(8'h96, 0, 0, -1);
    chk("R3 even ok", reg_rdata[2], 0);
    clr_all();
    send(8'h97, 1, 0, -1);
    chk("R3 even bad", reg_rdata[2:0], 3'b101);
    chk_data("R3 stored", 8'h97);
    clr_all();
    wreg(2'd0, 4'b0111);
    send(8'h07, 0, 0, -1);
    chk("R3 odd ok", reg_rdata[2], 0);
    clr_all();
    wreg(2'd0, 4'b1001);
    send(8'hFF, 0, 0, -1);
    chk_data("R3 seven bit", 8'h7F);
    clr_all();
    wreg(2'd0, 4'b1111);
    send(8'h55, 1, 0, -1);
    chk("R3 odd bad", reg_rdata[2], 1);
    chk_data("R3 seven odd", 8'h55);
    clr_all();

    wreg(2'd0, 4'b0001);
    send(8'hC3, 0, 1, -1);
    chk("R5 framing", reg_rdata[3:0], 4'b1000);
    chk_data("R5 stored", 8'hC3);
    rxd = 0;
    repeat (40) @(negedge clk);
    chk("R11 break", reg_rdata[4], 0);
    rxd = 1;
    repeat (4) @(negedge clk);
    clr_all();

    rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (200) @(negedge clk);
    chk("R4 glitch", reg_rdata[3:0], 0);
    send(8'h5A, 0, 0, -1);
    chk_data("R4 after glitch", 8'h5A);
    clr_all();

    send(8'h81, 0, 0, 3);
    chk("R10 abort", reg_rdata[3:0], 0);
    chk_data("R10 abort data", 8'h5A);
    wreg(2'd0, 4'b0001);
    send(8'h18, 0, 0, -1);
    chk_data("R10 reenabled", 8'h18);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule